// File: doc/BRIEF.md
# ATA card host bus decoder

The block is the card-side decode front end of a removable ATA storage card. It watches the host address lines, two active-low enables, an attribute-select input, the read and write strobes, a mode-select pin and a drive-select pin. From these it produces register-select strobes, byte-lane controls for the 16-bit data path, and one shared status pin. That pin means ready/busy, an active-low interrupt or an active-high interrupt, depending on the access mode.

The mode is sampled once, at the first clock edge after reset is released. A low mode-select pin picks direct IDE operation. Otherwise the card acts as a PC Card, in memory-mapped or I/O-mapped form as selected by the configuration input. In IDE mode the two enables act as chip selects: the first reaches the task file and the second reaches the control block. In the PC Card modes the enables steer bytes, so that an 8-bit host can reach odd bytes on the low lane. The register contents, the media engine and the card information storage sit outside the block. Their effect arrives through the init-done and interrupt-event inputs.

Top module: `ata_bus_decode`

## Requirements
- R1: mode_o is sampled at the first clock edge after reset release: mode_sel_i low gives IDE (2), and high gives I/O (1) when io_cfg_i is 1 or memory (0) when io_cfg_i is 0. Later changes of mode_sel_i have no effect on mode_o.
- R2: In IDE mode, with en_n_i[0] low and rd_n_i or wr_n_i low, tf_sel_o is one-hot with bit addr_i[2:0] set. Otherwise tf_sel_o is 0. reg_addr_o carries addr_i[2:0] with every higher bit forced to 0.
- R3: In IDE mode, with en_n_i[1] low and addr_i[2:0]=6, ctl_rd_o follows rd_n_i low and ctl_wr_o follows wr_n_i low. Both are 0 in any other case.
- R4: In PC Card modes the lane outputs are decoded from the enables. Both enables low gives lane_lo_o=1 and lane_hi_o=1. Only en_n_i[0] low gives lane_lo_o=1, lane_hi_o=0 and odd_to_lo_o=addr_i[0]. Only en_n_i[1] low gives lane_hi_o=1 alone. Neither low gives all three at 0.
- R5: In IDE mode, either chip select low gives lane_lo_o=1 and odd_to_lo_o=0. lane_hi_o=1 only when en_n_i[0] is low and addr_i[2:0]=0 (the 16-bit data register).
- R6: In PC Card modes, with any enable low and a strobe low, attr_n_i low asserts attr_sel_o. With attr_n_i high, memory mode asserts common_sel_o and I/O mode asserts io_sel_o. reg_addr_o equals addr_i.
- R7: In memory mode irq_rdy_o is 0 after reset until init_done_i is seen high at a clock edge. From the next cycle on it is 1 and stays 1.
- R8: In I/O mode with irq_level_i=0, an irq_evt_i sampled at an edge drives irq_rdy_o low for exactly PULSE_W cycles, starting after that edge. Its idle level is 1.
- R9: In I/O mode with irq_level_i=1, an event holds irq_rdy_o low until a status read: io_sel_o active with addr_i[2:0]=7 and rd_n_i low at an edge. A read at any other offset does not clear it.
- R10: In IDE mode irq_rdy_o is active high. An event sets it, and a status read (en_n_i[0] low, addr_i[2:0]=7, rd_n_i low) at an edge clears it.
- R11: master_o is 1 when drive_sel_n_i is low (grounded) and 0 when it is high (left open).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_sel_i | input | 1 | Mode pin, low selects IDE at reset |
| io_cfg_i | input | 1 | Card configured for I/O-mapped access |
| addr_i | input | ADDR_W | Host address |
| en_n_i | input | 2 | Card enables / chip selects, active low |
| attr_n_i | input | 1 | Low selects attribute space |
| rd_n_i | input | 1 | Read strobe, active low |
| wr_n_i | input | 1 | Write strobe, active low |
| drive_sel_n_i | input | 1 | Drive select pin, low means master |
| init_done_i | input | 1 | Internal initialisation finished |
| irq_evt_i | input | 1 | Interrupt event from the media engine |
| irq_level_i | input | 1 | 1 selects level interrupt, 0 selects pulse |
| mode_o | output | 2 | 0 memory, 1 I/O, 2 IDE |
| tf_sel_o | output | 8 | One-hot task-file register select |
| ctl_rd_o | output | 1 | Alternate status read |
| ctl_wr_o | output | 1 | Device control write |
| common_sel_o | output | 1 | Common memory access |
| attr_sel_o | output | 1 | Attribute space access |
| io_sel_o | output | 1 | I/O space access |
| reg_addr_o | output | ADDR_W | Address passed to the register file |
| lane_lo_o | output | 1 | Low data lane active |
| lane_hi_o | output | 1 | High data lane active |
| odd_to_lo_o | output | 1 | Odd byte routed onto the low lane |
| irq_rdy_o | output | 1 | Ready/busy or interrupt, meaning set by mode |
| master_o | output | 1 | Card is the master drive |

## Verification
The bench uses the default address width of 11 bits and a pulse width of 4. At this size every combination of the eight task-file offsets, the four enable patterns and the read, write and idle strobes can be swept in each mode, with non-zero upper address bits that show the IDE masking. The short pulse lets the bench count the interrupt cycle by cycle on both sides of its end. Across resets, every mode is reached, and so are both interrupt styles and the ready transition.

// File: rtl/ata_dec_pkg.sv
package ata_dec_pkg;
  typedef enum logic [1:0] {
    MODE_MEM = 2'd0,
    MODE_IO  = 2'd1,
    MODE_IDE = 2'd2
  } mode_e;
  localparam int unsigned TF_REGS  = 8;
  localparam int unsigned OFF_W    = 3;
  localparam int unsigned DATA_OFF = 0;
  localparam int unsigned CTL_OFF  = 6;
  localparam int unsigned STAT_OFF = 7;
endpackage

// File: rtl/ata_mode_latch.sv
module ata_mode_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mode_sel_i,
  output logic ide_o
);
  logic done_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      ide_o  <= 1'b0;
    end else if (!done_q) begin
      done_q <= 1'b1;
      ide_o  <= ~mode_sel_i;
    end
  end
endmodule

// File: rtl/ata_lane_steer.sv
module ata_lane_steer (
  input  logic       ide_i,
  input  logic [1:0] en_n_i,
  input  logic       a0_i,
  input  logic       data_reg_i,
  output logic       lo_o,
  output logic       hi_o,
  output logic       swap_o
);
  always_comb begin
    lo_o = 1'b0; hi_o = 1'b0; swap_o = 1'b0;
    if (ide_i) begin
      lo_o = ~&en_n_i;
      hi_o = ~en_n_i[0] & data_reg_i;
    end else begin
      unique case (en_n_i)
        2'b00: begin lo_o = 1'b1; hi_o = 1'b1; end
        2'b10: begin lo_o = 1'b1; swap_o = a0_i; end
        2'b01: hi_o = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ata_irq_gen.sv
module ata_irq_gen #(
  parameter int unsigned PULSE_W = 4,
  localparam int unsigned CNT_W  = $clog2(PULSE_W + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       level_i,
  input  logic       evt_i,
  input  logic       stat_rd_i,
  input  logic       init_done_i,
  output logic       pin_o
);
  import ata_dec_pkg::*;
  logic             ready_q, pend_q, active;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q <= 1'b0;
      pend_q  <= 1'b0;
      cnt_q   <= '0;
    end else begin
      if (init_done_i) ready_q <= 1'b1;
      if (evt_i)          pend_q <= 1'b1;
      else if (stat_rd_i) pend_q <= 1'b0;
      if (evt_i)              cnt_q <= CNT_W'(PULSE_W);
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end
  end

  always_comb begin
    active = (mode_i == MODE_IO && !level_i) ? (cnt_q != '0) : pend_q;
    unique case (mode_i)
      MODE_IO:  pin_o = ~active;
      MODE_IDE: pin_o = active;
      default:  pin_o = ready_q;
    endcase
  end
endmodule

// File: rtl/ata_bus_decode.sv
module ata_bus_decode #(
  parameter int unsigned ADDR_W  = 11,
  parameter int unsigned PULSE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_sel_i,
  input  logic              io_cfg_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        en_n_i,
  input  logic              attr_n_i,
  input  logic              rd_n_i,
  input  logic              wr_n_i,
  input  logic              drive_sel_n_i,
  input  logic              init_done_i,
  input  logic              irq_evt_i,
  input  logic              irq_level_i,
  output logic [1:0]        mode_o,
  output logic [7:0]        tf_sel_o,
  output logic              ctl_rd_o,
  output logic              ctl_wr_o,
  output logic              common_sel_o,
  output logic              attr_sel_o,
  output logic              io_sel_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic              lane_lo_o,
  output logic              lane_hi_o,
  output logic              odd_to_lo_o,
  output logic              irq_rdy_o,
  output logic              master_o
);
  import ata_dec_pkg::*;

  logic             ide, io, strobe, any_en, stat_rd;
  logic [OFF_W-1:0] off;

  ata_mode_latch u_mode (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_sel_i(mode_sel_i), .ide_o(ide)
  );

  assign mode_o = ide ? MODE_IDE : (io_cfg_i ? MODE_IO : MODE_MEM);
  assign io     = (mode_o == MODE_IO);
  assign off    = addr_i[OFF_W-1:0];
  assign strobe = ~rd_n_i | ~wr_n_i;
  assign any_en = ~&en_n_i;

  for (genvar r = 0; r < TF_REGS; r++) begin : g_tf
    assign tf_sel_o[r] = ide & ~en_n_i[0] & strobe & (off == OFF_W'(r));
  end

  for (genvar b = 0; b < ADDR_W; b++) begin : g_addr
    if (b < OFF_W) begin : g_low
      assign reg_addr_o[b] = addr_i[b];
    end else begin : g_high
      assign reg_addr_o[b] = ~ide & addr_i[b];
    end
  end

  assign ctl_rd_o     = ide & ~en_n_i[1] & ~rd_n_i & (off == OFF_W'(CTL_OFF));
  assign ctl_wr_o     = ide & ~en_n_i[1] & ~wr_n_i & (off == OFF_W'(CTL_OFF));
  assign attr_sel_o   = ~ide & any_en & strobe & ~attr_n_i;
  assign common_sel_o = (mode_o == MODE_MEM) & any_en & strobe & attr_n_i;
  assign io_sel_o     = io & any_en & strobe & attr_n_i;
  assign master_o     = ~drive_sel_n_i;

  assign stat_rd = ~rd_n_i & (off == OFF_W'(STAT_OFF)) &
                   ((ide & ~en_n_i[0]) | (io & any_en & attr_n_i));

  ata_lane_steer u_lane (
    .ide_i(ide), .en_n_i(en_n_i), .a0_i(addr_i[0]),
    .data_reg_i(off == OFF_W'(DATA_OFF)),
    .lo_o(lane_lo_o), .hi_o(lane_hi_o), .swap_o(odd_to_lo_o)
  );

  ata_irq_gen #(.PULSE_W(PULSE_W)) u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_o), .level_i(irq_level_i),
    .evt_i(irq_evt_i), .stat_rd_i(stat_rd), .init_done_i(init_done_i),
    .pin_o(irq_rdy_o)
  );
endmodule

// File: rtl/ata_bus_decode_chk.sv
module ata_bus_decode_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] mode_o,
  input logic [7:0] tf_sel_o,
  input logic       ctl_rd_o,
  input logic       ctl_wr_o,
  input logic       lane_lo_o,
  input logic       lane_hi_o,
  input logic       odd_to_lo_o,
  input logic       irq_rdy_o
);
  logic started_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) started_q <= 1'b0;
    else         started_q <= 1'b1;
  end

  assert_mode_held_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started_q |=> $stable(mode_o[1]));
  assert_tf_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(tf_sel_o));
  assert_tf_ide_only_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tf_sel_o != 8'd0) |-> (mode_o == 2'd2));
  assert_ctl_ide_only_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_rd_o || ctl_wr_o) |-> (mode_o == 2'd2));
  assert_swap_low_only_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    odd_to_lo_o |-> (lane_lo_o && !lane_hi_o));
  assert_ready_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd0 && irq_rdy_o) |=> (mode_o != 2'd0 || irq_rdy_o));
endmodule

bind ata_bus_decode ata_bus_decode_chk chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_o(mode_o), .tf_sel_o(tf_sel_o),
  .ctl_rd_o(ctl_rd_o), .ctl_wr_o(ctl_wr_o), .lane_lo_o(lane_lo_o),
  .lane_hi_o(lane_hi_o), .odd_to_lo_o(odd_to_lo_o), .irq_rdy_o(irq_rdy_o)
);

// File: tb/ata_bus_decode_tb_top.sv
module ata_bus_decode_tb_top;
  localparam int unsigned ADDR_W  = 11;
  localparam int unsigned PULSE_W = 4;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic mode_sel, io_cfg, attr_n, rd_n, wr_n, drv_n, init_done, evt, level;
  logic [ADDR_W-1:0] addr;
  logic [1:0] en_n;
  logic [1:0] mode;
  logic [7:0] tf_sel;
  logic ctl_rd, ctl_wr, com_sel, att_sel, io_sel, lo, hi, swp, pin, master;
  logic [ADDR_W-1:0] raddr;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  ata_bus_decode #(.ADDR_W(ADDR_W), .PULSE_W(PULSE_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .mode_sel_i(mode_sel), .io_cfg_i(io_cfg),
    .addr_i(addr), .en_n_i(en_n), .attr_n_i(attr_n), .rd_n_i(rd_n), .wr_n_i(wr_n),
    .drive_sel_n_i(drv_n), .init_done_i(init_done), .irq_evt_i(evt),
    .irq_level_i(level), .mode_o(mode), .tf_sel_o(tf_sel), .ctl_rd_o(ctl_rd),
    .ctl_wr_o(ctl_wr), .common_sel_o(com_sel), .attr_sel_o(att_sel),
    .io_sel_o(io_sel), .reg_addr_o(raddr), .lane_lo_o(lo), .lane_hi_o(hi),
    .odd_to_lo_o(swp), .irq_rdy_o(pin), .master_o(master)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle();
    en_n = 2'b11; rd_n = 1'b1; wr_n = 1'b1; attr_n = 1'b1; evt = 1'b0;
    addr = '0;
  endtask

  task automatic do_reset(logic ms, logic cfg);
    @(negedge clk);
    rst_ni = 1'b0; mode_sel = ms; io_cfg = cfg; init_done = 1'b0; level = 1'b0;
    drv_n = 1'b1; idle();
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(posedge clk); #1;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  // one access with comb checks; op: 0 read, 1 write, 2 none
  task automatic access(bit ide, int e, int o, int a, int at);
    int exp_tf, lo_e, hi_e, sw_e, strb, any;
    @(negedge clk);
    en_n = 2'(e); rd_n = (o != 0); wr_n = (o != 1); attr_n = at[0];
    addr = ADDR_W'(a);
    #1;
    strb = (o != 2); any = (e != 3);
    if (ide) begin
      exp_tf = (!e[0] && strb) ? (1 << (a % 8)) : 0;
      chk("R2 tf_sel", tf_sel, exp_tf);
      chk("R2 reg_addr", raddr, a % 8);
      chk("R3 ctl_rd", ctl_rd, (!e[1] && a % 8 == 6 && o == 0));
      chk("R3 ctl_wr", ctl_wr, (!e[1] && a % 8 == 6 && o == 1));
      chk("R5 lane_lo", lo, any);
      chk("R5 lane_hi", hi, (!e[0] && a % 8 == 0));
      chk("R5 swap", swp, 0);
    end else begin
      lo_e = (e == 0 || e == 2); hi_e = (e == 0 || e == 1);
      sw_e = (e == 2) && a[0];
      chk("R4 lane_lo", lo, lo_e);
      chk("R4 lane_hi", hi, hi_e);
      chk("R4 swap", swp, sw_e);
      chk("R6 attr_sel", att_sel, any && strb && !at[0]);
      chk("R6 common_sel", com_sel, any && strb && at[0] && !io_cfg);
      chk("R6 io_sel", io_sel, any && strb && at[0] && io_cfg);
      chk("R6 reg_addr", raddr, a);
      chk("R2 tf_idle_pc", tf_sel, 0);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    // IDE mode
    do_reset(1'b0, 1'b0);
    chk("R1 mode ide", mode, 2);
    chk("R10 irq idle", pin, 0);
    @(negedge clk); mode_sel = 1'b1; tick(); tick();
    chk("R1 mode held", mode, 2);
    for (int a = 0; a < 8; a++)
      for (int e = 0; e < 4; e++)
        for (int o = 0; o < 3; o++)
          access(1, e, o, a | (((a * 37 + 5) % 256) << 3), 1);
    @(negedge clk); idle(); evt = 1'b1;
    tick(); chk("R10 irq set", pin, 1);
    @(negedge clk); evt = 1'b0; tick(); tick();
    chk("R10 irq held", pin, 1);
    @(negedge clk); en_n = 2'b01; rd_n = 1'b0; addr = 11'd7; // cs1 only: no clear
    tick(); chk("R10 cs1 no clear", pin, 1);
    @(negedge clk); en_n = 2'b10; rd_n = 1'b0; addr = 11'h7f;
    tick(); @(negedge clk); idle(); #1;
    chk("R10 irq cleared", pin, 0);
    drv_n = 1'b0; #1 chk("R11 master", master, 1);
    drv_n = 1'b1; #1 chk("R11 slave", master, 0);

    // memory mode
    do_reset(1'b1, 1'b0);
    chk("R1 mode mem", mode, 0);
    chk("R7 busy at reset", pin, 0);
    tick(); tick(); chk("R7 busy held", pin, 0);
    @(negedge clk); init_done = 1'b1; #1 chk("R7 busy before edge", pin, 0);
    tick(); chk("R7 ready", pin, 1);
    @(negedge clk); init_done = 1'b0; tick(); tick();
    chk("R7 ready sticky", pin, 1);
    for (int e = 0; e < 4; e++)
      for (int a0 = 0; a0 < 2; a0++)
        for (int at = 0; at < 2; at++)
          for (int o = 0; o < 3; o++)
            access(0, e, o, 11'h5a4 | a0, at);

    // I/O mode
    @(negedge clk); io_cfg = 1'b1; idle(); #1;
    chk("R1 mode io", mode, 1);
    chk("R8 irq idle high", pin, 1);
    for (int e = 0; e < 4; e++)
      for (int a0 = 0; a0 < 2; a0++)
        for (int at = 0; at < 2; at++)
          for (int o = 0; o < 3; o++)
            access(0, e, o, 11'h3c6 | a0, at);
    @(negedge clk); idle(); level = 1'b0; evt = 1'b1;
    tick();
    for (int i = 0; i < 7; i++) begin
      chk($sformatf("R8 pulse cycle %0d", i), pin, (i < PULSE_W) ? 0 : 1);
      @(negedge clk); evt = 1'b0;
      tick();
    end
    @(negedge clk); level = 1'b1; evt = 1'b1;
    tick(); @(negedge clk); evt = 1'b0;
    repeat (PULSE_W + 2) tick();
    chk("R9 level held", pin, 0);
    @(negedge clk); en_n = 2'b10; rd_n = 1'b0; addr = 11'd6;
    tick(); @(negedge clk); idle(); #1;
    chk("R9 other offset no clear", pin, 0);
    @(negedge clk); en_n = 2'b10; rd_n = 1'b0; addr = 11'd7;
    tick(); @(negedge clk); idle(); #1;
    chk("R9 status read clears", pin, 1);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule